// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block holds the interrupt request register of one interrupt controller. Each of its eight request lines is sampled on every clock. A per-line trigger-mode bit selects what the sample does. In level mode the request bit tracks the line. In edge mode the request bit is set on a low-to-high transition and is held until the line is acknowledged. A fixed, per-instance constant limits which lines may be switched to level mode at all. Lines outside that constant are always edge triggered.

The block also holds the interrupt mask register. It presents the lines that can take part in priority resolution, which are the ones requested and not masked. For every trigger event it reports, one cycle later, either a new unmasked request or a hit on a masked line. A separate priority stage takes these outputs. That stage returns an acknowledge strobe with a line number. The controller's initialisation command arrives as a single strobe. The request, mask and trigger-mode registers can be read and written one at a time over a small byte-wide register port.

Top module: `irq_req_latch`

## Requirements
- R1: After reset the request, mask and trigger-mode registers read 0, and `new_req_o`, `masked_hit_o` and `eligible_o` are 0.
- R2: For a line in level mode (trigger bit 1), the request bit equals the line's input as sampled at the previous clock edge.
- R3: For a line in edge mode (trigger bit 0), the request bit becomes 1 one cycle after the input is sampled high following a low sample. An input held high produces no further trigger event.
- R4: In edge mode, a low input clears the stored last-level bit but leaves a latched request bit at 1.
- R5: An acknowledge (`ack_i` with `ack_line_i`) clears that line's request bit only in edge mode. If a fresh edge arrives on the same line in the same cycle, the request stays set. In level mode the request keeps following the input.
- R6: Writing the trigger-mode register (`reg_addr_i` = 2) stores `reg_wdata_i & TRIG_MASK`. With the default TRIG_MASK of 0xF8, lines 0, 1 and 2 stay in edge mode.
- R7: Writing the mask register (`reg_addr_i` = 1) stores the byte. `eligible_o` is request AND NOT mask.
- R8: A trigger event is a sampled high input in level mode, or a rising edge in edge mode. On an unmasked line whose request bit was 0, a trigger event pulses `new_req_o` for that line one cycle later. On a masked line it pulses `masked_hit_o` instead and still updates the request bit. Both outputs use the mask as it was before the edge.
- R9: `init_i` clears the request, last-level and mask registers, blocks any register write in the same cycle, and keeps the trigger-mode register. An edge-mode input that is still high therefore produces a request one cycle after the init.
- R10: `reg_rdata_o` shows the register selected by `reg_addr_i`: 0 gives the request register, 1 the mask, 2 the trigger mode and 3 gives zero. Writes to addresses 0 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in_i | input | N_LINES | Request input lines |
| init_i | input | 1 | Controller initialisation strobe |
| ack_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | LINE_W | Line being acknowledged |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | N_LINES | Register write data |
| reg_rdata_o | output | N_LINES | Selected register contents |
| req_o | output | N_LINES | Request register |
| eligible_o | output | N_LINES | Requests not masked |
| new_req_o | output | N_LINES | New unmasked request pulse per line |
| masked_hit_o | output | N_LINES | Trigger event on a masked line, per line |

## Verification
The hardest case to reach from the ports is the hidden last-level bit after an init. This bit cannot be read back. Its only visible effect is that an edge-mode input held high across the init produces a new request afterwards. To reach it, the bench holds line 0 high until its request is latched and then acknowledges it. The request then stays clear while the input remains high. Only after that does the bench issue the init. The bench also drives an acknowledge in the same cycle as a fresh rising edge on that line, and it drives a trigger event on a masked line.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;

    typedef enum logic [1:0] {
        SEL_REQ  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_TRIG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic req;
        logic last;
        logic new_evt;
        logic msk_evt;
    } line_state_t;

endpackage

// File: rtl/irqlat_line.sv
module irqlat_line
    import irqlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic level_i,
    input  logic mask_i,
    input  logic ack_hit_i,
    input  logic init_i,
    output logic req_o,
    output logic new_o,
    output logic masked_o
);

    line_state_t st_d, st_q;
    logic        trig_evt;

    always_comb begin
        st_d     = st_q;
        trig_evt = level_i ? irq_i : (irq_i & ~st_q.last);
        st_d.last = irq_i;
        if (level_i) begin
            st_d.req = irq_i;
        end else begin
            st_d.req = (st_q.req & ~ack_hit_i) | trig_evt;
        end
        st_d.new_evt = trig_evt & ~st_q.req & ~mask_i;
        st_d.msk_evt = trig_evt & mask_i;
        if (init_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o    = st_q.req;
    assign new_o    = st_q.new_evt;
    assign masked_o = st_q.msk_evt;

endmodule

// File: rtl/irqlat_regs.sv
module irqlat_regs
    import irqlat_pkg::*;
#(
    parameter int                 N_LINES   = 8,
    parameter logic [N_LINES-1:0] TRIG_MASK = 'hF8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               wr_i,
    input  reg_sel_e           sel_i,
    input  logic [N_LINES-1:0] wdata_i,
    output logic [N_LINES-1:0] mask_o,
    output logic [N_LINES-1:0] trig_o
);

    typedef struct packed {
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] trig;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (init_i) begin
            cfg_d.mask = '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_MASK: cfg_d.mask = wdata_i;
                SEL_TRIG: cfg_d.trig = wdata_i & TRIG_MASK;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_o = cfg_q.mask;
    assign trig_o = cfg_q.trig;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irqlat_pkg::*;
#(
    parameter int                 N_LINES   = 8,
    parameter logic [N_LINES-1:0] TRIG_MASK = 'hF8,
    localparam int                LINE_W    = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in_i,
    input  logic               init_i,
    input  logic               ack_i,
    input  logic [LINE_W-1:0]  ack_line_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [N_LINES-1:0] reg_wdata_i,
    output logic [N_LINES-1:0] reg_rdata_o,
    output logic [N_LINES-1:0] req_o,
    output logic [N_LINES-1:0] eligible_o,
    output logic [N_LINES-1:0] new_req_o,
    output logic [N_LINES-1:0] masked_hit_o
);

    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] trig_q;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(reg_addr_i);

    irqlat_regs #(
        .N_LINES   (N_LINES),
        .TRIG_MASK (TRIG_MASK)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_i),
        .wr_i    (reg_wr_i),
        .sel_i   (sel),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_q),
        .trig_o  (trig_q)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic ack_hit;
        assign ack_hit = ack_i && (ack_line_i == LINE_W'(i));

        irqlat_line i_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_i     (irq_in_i[i]),
            .level_i   (trig_q[i]),
            .mask_i    (mask_q[i]),
            .ack_hit_i (ack_hit),
            .init_i    (init_i),
            .req_o     (req_o[i]),
            .new_o     (new_req_o[i]),
            .masked_o  (masked_hit_o[i])
        );
    end

    assign eligible_o = req_o & ~mask_q;

    always_comb begin
        case (sel)
            SEL_REQ:  reg_rdata_o = req_o;
            SEL_MASK: reg_rdata_o = mask_q;
            SEL_TRIG: reg_rdata_o = trig_q;
            default:  reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqlat_chk.sv
module irqlat_chk #(
    parameter int                 N_LINES   = 8,
    parameter logic [N_LINES-1:0] TRIG_MASK = 'hF8,
    localparam int                LINE_W    = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_in_i,
    input logic               init_i,
    input logic               ack_i,
    input logic [LINE_W-1:0]  ack_line_i,
    input logic [1:0]         reg_addr_i,
    input logic [N_LINES-1:0] reg_rdata_o,
    input logic [N_LINES-1:0] req_o,
    input logic [N_LINES-1:0] new_req_o,
    input logic [N_LINES-1:0] masked_hit_o,
    input logic [N_LINES-1:0] mask_q,
    input logic [N_LINES-1:0] trig_q
);

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (((req_o ^ $past(irq_in_i)) & $past(trig_q)) == '0));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !ack_i) |=> (($past(req_o) & ~$past(trig_q) & ~req_o) == '0));

    // R5
    level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !init_i && trig_q[ack_line_i] && irq_in_i[ack_line_i])
        |=> req_o[$past(ack_line_i)]);

    // R5
    edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !init_i && !trig_q[ack_line_i] && !irq_in_i[ack_line_i])
        |=> !req_o[$past(ack_line_i)]);

    // R6
    trig_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 2'd2) |-> ((reg_rdata_o & ~TRIG_MASK) == '0));

    // R8
    masked_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (((masked_hit_o & ~$past(mask_q)) == '0)
                     && ((new_req_o & $past(mask_q)) == '0)));

    // R9
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> ((req_o == '0) && (mask_q == '0) && (trig_q == $past(trig_q))));

endmodule

bind irq_req_latch irqlat_chk #(
    .N_LINES   (N_LINES),
    .TRIG_MASK (TRIG_MASK)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_in_i     (irq_in_i),
    .init_i       (init_i),
    .ack_i        (ack_i),
    .ack_line_i   (ack_line_i),
    .reg_addr_i   (reg_addr_i),
    .reg_rdata_o  (reg_rdata_o),
    .req_o        (req_o),
    .new_req_o    (new_req_o),
    .masked_hit_o (masked_hit_o),
    .mask_q       (mask_q),
    .trig_q       (trig_q)
);

// File: tb/test_irq_req_latch.sv
`timescale 1ns/1ps
module test_irq_req_latch;

    localparam logic [7:0] TMASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       init = 1'b0;
    logic       ack = 1'b0;
    logic [2:0] ack_line = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, req, eligible, new_req, masked_hit;

    always #4 clk = ~clk;

    irq_req_latch i_irq_req_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in_i     (irq_in),
        .init_i       (init),
        .ack_i        (ack),
        .ack_line_i   (ack_line),
        .reg_wr_i     (reg_wr),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .req_o        (req),
        .eligible_o   (eligible),
        .new_req_o    (new_req),
        .masked_hit_o (masked_hit)
    );

    typedef struct {
        string      tag;
        logic [7:0] req;
        logic [7:0] elig;
        logic [7:0] nw;
        logic [7:0] mh;
        logic [7:0] rd;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // reference state, built from the requirements
    logic [7:0] m_req = '0, m_last = '0, m_mask = '0, m_trig = '0;

    task automatic step(input logic [7:0] in, input logic a, input logic [2:0] al,
                        input logic in_init, input logic wr, input logic [1:0] ad,
                        input logic [7:0] wd, input string tag);
        logic [7:0] ev, n_req, n_new, n_mh, n_mask, n_trig, clr, rd;
        item_t it;
        @(negedge clk);
        irq_in = in; ack = a; ack_line = al; init = in_init;
        reg_wr = wr; reg_addr = ad; reg_wdata = wd;
        ev    = (m_trig & in) | (~m_trig & in & ~m_last);
        clr   = a ? (8'h01 << al) & ~m_trig : 8'h00;
        n_req = (m_trig & in) | (~m_trig & ((m_req & ~clr) | ev));
        n_new = ev & ~m_req & ~m_mask;
        n_mh  = ev & m_mask;
        n_mask = m_mask;
        n_trig = m_trig;
        if (wr && ad == 2'd1) n_mask = wd;
        if (wr && ad == 2'd2) n_trig = wd & TMASK;
        if (in_init) begin
            n_req = '0; n_new = '0; n_mh = '0; n_mask = '0; n_trig = m_trig;
            m_last = '0;
        end else begin
            m_last = in;
        end
        m_req = n_req; m_mask = n_mask; m_trig = n_trig;
        case (ad)
            2'd0: rd = m_req;
            2'd1: rd = m_mask;
            2'd2: rd = m_trig;
            default: rd = '0;
        endcase
        it.tag = tag; it.req = m_req; it.elig = m_req & ~m_mask;
        it.nw = n_new; it.mh = n_mh; it.rd = rd;
        q.push_back(it);
    endtask

    // monitor: compares one item per cycle, between edges
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (req !== it.req || eligible !== it.elig || new_req !== it.nw ||
                    masked_hit !== it.mh || reg_rdata !== it.rd) begin
                    errors++;
                    $display("FAIL %s: req=%h elig=%h new=%h mhit=%h rd=%h expected req=%h elig=%h new=%h mhit=%h rd=%h",
                             it.tag, req, eligible, new_req, masked_hit, reg_rdata,
                             it.req, it.elig, it.nw, it.mh, it.rd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, read each register
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R1 reset req");
        step(8'h00, 0, 0, 0, 0, 2'd1, 8'h00, "R1 reset mask");
        step(8'h00, 0, 0, 0, 0, 2'd2, 8'h00, "R1 reset trig");
        // R6 trigger write masked by constant
        step(8'h00, 0, 0, 0, 1, 2'd2, 8'hFF, "R6 trig write FF");
        step(8'h00, 0, 0, 0, 0, 2'd2, 8'h00, "R6 trig readback F8");
        // R2 level lines follow input
        step(8'h08, 0, 0, 0, 0, 2'd0, 8'h00, "R2 level high");
        step(8'h08, 0, 0, 0, 0, 2'd0, 8'h00, "R2 level held");
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R2 level low");
        step(8'hA0, 0, 0, 0, 0, 2'd0, 8'h00, "R2 level pattern");
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R2 level clear");
        // R3 edge line 0
        step(8'h01, 0, 0, 0, 0, 2'd0, 8'h00, "R3 edge rise");
        step(8'h01, 0, 0, 0, 0, 2'd0, 8'h00, "R3 edge held no event");
        // R4 low does not clear latched request
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R4 edge low keeps req");
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R4 edge low keeps req again");
        // R5 ack behaviour
        step(8'h00, 1, 0, 0, 0, 2'd0, 8'h00, "R5 edge ack clears");
        step(8'h10, 0, 0, 0, 0, 2'd0, 8'h00, "R5 level set");
        step(8'h10, 1, 4, 0, 0, 2'd0, 8'h00, "R5 level ack keeps");
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R5 level release");
        step(8'h02, 1, 1, 0, 0, 2'd0, 8'h00, "R5 ack with fresh edge");
        step(8'h00, 1, 1, 0, 0, 2'd0, 8'h00, "R5 ack line1 clears");
        // R7 mask and eligible
        step(8'h00, 0, 0, 0, 1, 2'd1, 8'h06, "R7 mask write");
        step(8'h02, 0, 0, 0, 0, 2'd1, 8'h00, "R8 masked edge hit");
        step(8'h0A, 0, 0, 0, 0, 2'd0, 8'h00, "R7 eligible excludes masked");
        step(8'h0C, 0, 0, 0, 0, 2'd0, 8'h00, "R8 masked edge line2");
        step(8'h08, 0, 0, 0, 1, 2'd1, 8'h00, "R8 old mask used on write cycle");
        step(8'h00, 0, 0, 0, 0, 2'd1, 8'h00, "R7 unmasked eligible");
        // R10 ignored writes and read select
        step(8'h00, 0, 0, 0, 1, 2'd0, 8'hFF, "R10 write req ignored");
        step(8'h00, 0, 0, 0, 1, 2'd3, 8'hFF, "R10 write addr3 ignored");
        step(8'h00, 0, 0, 0, 0, 2'd2, 8'h00, "R10 read trig intact");
        step(8'h00, 1, 1, 0, 0, 2'd0, 8'h00, "R5 clear line1");
        step(8'h00, 1, 2, 0, 0, 2'd0, 8'h00, "R5 clear line2");
        // R9 init re-arms edge on a held input
        step(8'h01, 0, 0, 0, 1, 2'd1, 8'h40, "R9 prep rise");
        step(8'h01, 1, 0, 0, 0, 2'd0, 8'h00, "R9 prep ack");
        step(8'h01, 0, 0, 0, 0, 2'd0, 8'h00, "R9 held no retrigger");
        step(8'h01, 0, 0, 1, 1, 2'd1, 8'hFF, "R9 init clears mask blocks write");
        step(8'h01, 0, 0, 0, 0, 2'd2, 8'h00, "R9 rearmed and trig kept");
        step(8'h01, 0, 0, 1, 0, 2'd0, 8'h00, "R9 init clears req");
        // sweep of level/edge mixes
        for (int k = 0; k < 8; k++) begin
            step(8'h11 << (k % 4), 0, 0, 0, 0, 2'd0, 8'h00, "R2 R3 sweep");
            step(8'h00, 1, 3'(k), 0, 0, 2'd0, 8'h00, "R5 sweep ack");
        end
        step(8'h00, 0, 0, 0, 0, 2'd0, 8'h00, "R4 sweep end");
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule